// File: doc/BRIEF.md
# Gradient Search Vector Generator

This block steers a gradient-descent motion search and remembers the best motion vector seen so far. A sequencer drives it with plain command pulses. `init_i` seeds the search from a predicted vector. A gradient strobe supplies the signed horizontal and vertical error gradients: the block quantises their negation to one of eight unit moves, and it either starts a new line search from the best vector found so far or stops the search. A step pulse advances the current vector by one pixel along the stored move.

Evaluation bookkeeping uses two valid/ready streams. On the issue stream, the sequencer records the current vector as "being evaluated". The block asserts `iss_ready_o` while its small vector queue has room; when the queue is full it holds `iss_ready_o` low, and an issue offered then is not taken. On the result stream, error values come back in issue order. The block asserts `res_ready_o` only while a vector is waiting; a result offered when nothing is waiting is not taken. Each accepted result is paired with the oldest waiting vector, which lets the evaluation pipeline run ahead of the comparison. `done_o` tells the sequencer to finish the current instruction.

Top module: `grad_search_vecgen`

## Requirements
- R1: After reset the current and best vectors are (0,0), the best error is all ones, `done_o` is 0, `iss_ready_o` is 1 and `res_ready_o` is 0.
- R2: `init_i` loads the predicted vector into both the current and best vectors, sets the best error to all ones, forgets the stored direction, zeroes the step and iteration counts and empties the vector queue. It has priority over every other command in the same cycle.
- R3: A gradient pair (gx,gy) is quantised to the unit move (dx,dy). Here dx = -sign(gx) unless 12*|gx| < 5*|gy|, in which case dx = 0, and dy is formed the same way with the roles of the two components swapped. `dir_o` encodes the move: 0=(+1,0), 1=(+1,+1), 2=(0,+1), 3=(-1,+1), 4=(-1,0), 5=(-1,-1), 6=(0,-1), 7=(+1,-1).
- R4: An accepted gradient stores its direction, loads the current vector from the best vector, clears the step count and adds one to the iteration count.
- R5: A gradient whose quantised direction equals the direction stored since the last `init_i` is not accepted. It pulses `done_o` and leaves the current vector and the stored direction unchanged.
- R6: A gradient is not accepted, and it pulses `done_o`, when both of its components are zero or when ITERS (default 2) gradients have already been accepted since `init_i`.
- R7: A step moves the current vector by (dx,dy). If the result would fall outside [-RANGE, RANGE] (default 16) on either axis, the vector stays where it is and `done_o` pulses. The current vector never leaves that range.
- R8: A step taken before any direction is stored, or after LUMP (default 3) steps have been taken in the current line, has no effect.
- R9: An issue pushes the current vector into the queue only when `iss_ready_o` is 1, and `iss_ready_o` is 0 exactly while FDEPTH (default 4) vectors are waiting.
- R10: An accepted result is paired with the oldest waiting vector. The best error and best vector are replaced only when the result is strictly smaller than the best error; a tie keeps the earlier vector.
- R11: `done_o` is high for one cycle: the cycle after the edge that sampled the stopping gradient or step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Seed the search from the predicted vector |
| pred_vx_i | input | VW | Predicted vector, horizontal (signed) |
| pred_vy_i | input | VW | Predicted vector, vertical (signed) |
| grad_valid_i | input | 1 | New gradient pair present |
| grad_x_i | input | GW | Horizontal gradient (signed) |
| grad_y_i | input | GW | Vertical gradient (signed) |
| step_i | input | 1 | Advance one pixel along the stored direction |
| iss_valid_i | input | 1 | Current vector enters evaluation |
| iss_ready_o | output | 1 | Queue has room for an issued vector |
| res_valid_i | input | 1 | Error result present |
| res_err_i | input | EW | Error value (unsigned) |
| res_ready_o | output | 1 | A vector waits for its result |
| cur_vx_o | output | VW | Current search vector, horizontal |
| cur_vy_o | output | VW | Current search vector, vertical |
| dir_o | output | 3 | Stored direction code |
| best_vx_o | output | VW | Best vector, horizontal |
| best_vy_o | output | VW | Best vector, vertical |
| best_err_o | output | EW | Best error so far |
| done_o | output | 1 | Finish pulse to the sequencer |

## Verification
Every result is registered: the vectors, direction, best error, queue flags and the finish pulse all appear one cycle after the edge that samples the command or stream beat. None of them is a combinational path from the inputs. The bench changes its inputs on the falling edge and drops them at the following falling edge, so exactly one rising edge sees each command. It reads the outputs at that second falling edge, which is inside the single cycle in which `done_o` is valid. Queue depth and pairing order are observed through the two ready flags and through the best vector and error, never through internal state.

// File: rtl/gsv_pkg.sv
package gsv_pkg;
  typedef logic [2:0] dir_code_t;

  // Unit move -> direction code, counter-clockwise from +x.
  function automatic dir_code_t dir_code(input logic signed [1:0] dx,
                                         input logic signed [1:0] dy);
    case ({dx, dy})
      4'b01_00: dir_code = 3'd0;
      4'b01_01: dir_code = 3'd1;
      4'b00_01: dir_code = 3'd2;
      4'b11_01: dir_code = 3'd3;
      4'b11_00: dir_code = 3'd4;
      4'b11_11: dir_code = 3'd5;
      4'b00_11: dir_code = 3'd6;
      4'b01_11: dir_code = 3'd7;
      default:  dir_code = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/gsv_dir_quant.sv
module gsv_dir_quant
  import gsv_pkg::*;
#(
  parameter int GW = 12
) (
  input  logic signed [GW-1:0] gx_i,
  input  logic signed [GW-1:0] gy_i,
  output logic                 zero_o,
  output logic signed [1:0]    dx_o,
  output logic signed [1:0]    dy_o,
  output dir_code_t            code_o
);
  localparam int MW = GW + 5;

  logic signed [GW:0] gxe, gye;
  logic [GW:0]        ax, ay;
  logic [MW-1:0]      ax12, ay12, ax5, ay5;
  logic               keep_x, keep_y;

  assign gxe = gx_i;
  assign gye = gy_i;

  always_comb begin
    ax   = gxe[GW] ? -gxe : gxe;
    ay   = gye[GW] ? -gye : gye;
    // 5/12 threshold built from shifts and adds
    ax12 = ({4'b0, ax} << 3) + ({4'b0, ax} << 2);
    ay12 = ({4'b0, ay} << 3) + ({4'b0, ay} << 2);
    ax5  = ({4'b0, ax} << 2) + {4'b0, ax};
    ay5  = ({4'b0, ay} << 2) + {4'b0, ay};
    keep_x = !(ax12 < ay5);
    keep_y = !(ay12 < ax5);
    // descend: move against the gradient sign
    if (!keep_x || gx_i == '0) dx_o = 2'sd0;
    else if (gx_i[GW-1])       dx_o = 2'sd1;
    else                       dx_o = -2'sd1;
    if (!keep_y || gy_i == '0) dy_o = 2'sd0;
    else if (gy_i[GW-1])       dy_o = 2'sd1;
    else                       dy_o = -2'sd1;
    zero_o = (gx_i == '0) && (gy_i == '0);
    code_o = dir_code(dx_o, dy_o);
  end
endmodule

// File: rtl/gsv_vec_fifo.sv
module gsv_vec_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == DEPTH_C);
  assign empty_o = (cnt == '0);
  assign dout_o  = mem[rp];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (clr_i) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr_i) mem[wp] <= din_i;
  end

  AST_FIFO_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH_C); // R9
  AST_FIFO_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !pop_i && !clr_i) |=> full_o && (wp == $past(wp))); // R9
endmodule

// File: rtl/gsv_best_track.sv
module gsv_best_track #(
  parameter int VW = 6,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed_i,
  input  logic [VW-1:0] seed_vx_i,
  input  logic [VW-1:0] seed_vy_i,
  input  logic          upd_i,
  input  logic [EW-1:0] err_i,
  input  logic [VW-1:0] vx_i,
  input  logic [VW-1:0] vy_i,
  output logic [VW-1:0] best_vx_o,
  output logic [VW-1:0] best_vy_o,
  output logic [EW-1:0] best_err_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_vx_o  <= '0;
      best_vy_o  <= '0;
      best_err_o <= '1;
    end else if (seed_i) begin
      best_vx_o  <= seed_vx_i;
      best_vy_o  <= seed_vy_i;
      best_err_o <= '1;
    end else if (upd_i && (err_i < best_err_o)) begin
      best_vx_o  <= vx_i;
      best_vy_o  <= vy_i;
      best_err_o <= err_i;
    end
  end

  AST_BEST_ERR_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_i |=> best_err_o <= $past(best_err_o)); // R10
  AST_BEST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_i && !upd_i) |=> $stable(best_vx_o) && $stable(best_vy_o)); // R10
endmodule

// File: rtl/grad_search_vecgen.sv
module grad_search_vecgen
  import gsv_pkg::*;
#(
  parameter int VW     = 6,
  parameter int GW     = 12,
  parameter int EW     = 16,
  parameter int RANGE  = 16,
  parameter int LUMP   = 3,
  parameter int ITERS  = 2,
  parameter int FDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic [VW-1:0] pred_vx_i,
  input  logic [VW-1:0] pred_vy_i,
  input  logic          grad_valid_i,
  input  logic [GW-1:0] grad_x_i,
  input  logic [GW-1:0] grad_y_i,
  input  logic          step_i,
  input  logic          iss_valid_i,
  output logic          iss_ready_o,
  input  logic          res_valid_i,
  input  logic [EW-1:0] res_err_i,
  output logic          res_ready_o,
  output logic [VW-1:0] cur_vx_o,
  output logic [VW-1:0] cur_vy_o,
  output logic [2:0]    dir_o,
  output logic [VW-1:0] best_vx_o,
  output logic [VW-1:0] best_vy_o,
  output logic [EW-1:0] best_err_o,
  output logic          done_o
);
  localparam int SW = $clog2(LUMP + 1);
  localparam int IW = $clog2(ITERS + 1);
  localparam logic [SW-1:0] LUMP_L  = SW'(LUMP);
  localparam logic [IW-1:0] ITERS_L = IW'(ITERS);
  localparam logic signed [VW:0] RHI = (VW+1)'(RANGE);
  localparam logic signed [VW:0] RLO = -RHI;

  // direction quantiser
  logic             q_zero;
  logic signed [1:0] q_dx, q_dy;
  dir_code_t        q_code;

  gsv_dir_quant #(.GW(GW)) u_quant (
    .gx_i(grad_x_i), .gy_i(grad_y_i),
    .zero_o(q_zero), .dx_o(q_dx), .dy_o(q_dy), .code_o(q_code)
  );

  // search state
  logic signed [VW-1:0] cur_x, cur_y;
  logic signed [1:0]    dx_q, dy_q;
  dir_code_t            code_q;
  logic                 have_dir;
  logic [SW-1:0]        steps_q;
  logic [IW-1:0]        iters_q;
  logic                 done_q;
  logic signed [VW:0]   nx, ny, cur_xe, cur_ye;
  logic                 nxt_ok, grad_stop;

  assign cur_xe = cur_x;
  assign cur_ye = cur_y;
  assign nx = cur_xe + VW'(dx_q);
  assign ny = cur_ye + VW'(dy_q);
  assign nxt_ok = (nx >= RLO) && (nx <= RHI) && (ny >= RLO) && (ny <= RHI);
  assign grad_stop = q_zero || (iters_q == ITERS_L) || (have_dir && (q_code == code_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_x <= '0; cur_y <= '0; dx_q <= '0; dy_q <= '0; code_q <= '0;
      have_dir <= 1'b0; steps_q <= '0; iters_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (init_i) begin
        cur_x <= pred_vx_i; cur_y <= pred_vy_i;
        dx_q <= '0; dy_q <= '0; code_q <= '0;
        have_dir <= 1'b0; steps_q <= '0; iters_q <= '0;
      end else if (grad_valid_i) begin
        if (grad_stop) begin
          done_q <= 1'b1;
        end else begin
          dx_q <= q_dx; dy_q <= q_dy; code_q <= q_code; have_dir <= 1'b1;
          cur_x <= best_vx_o; cur_y <= best_vy_o;
          steps_q <= '0; iters_q <= iters_q + 1'b1;
        end
      end else if (step_i && have_dir && (steps_q < LUMP_L)) begin
        if (nxt_ok) begin
          cur_x <= nx[VW-1:0]; cur_y <= ny[VW-1:0];
          steps_q <= steps_q + 1'b1;
        end else begin
          done_q <= 1'b1;
        end
      end
    end
  end

  // evaluation queue: vectors waiting for their error results
  logic              f_full, f_empty, f_push, f_pop;
  logic [2*VW-1:0]   f_dout;

  assign f_push = iss_valid_i && !init_i;
  assign f_pop  = res_valid_i && !init_i;

  gsv_vec_fifo #(.W(2*VW), .DEPTH(FDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr_i(init_i),
    .push_i(f_push), .din_i({cur_x, cur_y}),
    .pop_i(f_pop), .dout_o(f_dout), .full_o(f_full), .empty_o(f_empty)
  );

  gsv_best_track #(.VW(VW), .EW(EW)) u_best (
    .clk(clk), .rst_n(rst_n),
    .seed_i(init_i), .seed_vx_i(pred_vx_i), .seed_vy_i(pred_vy_i),
    .upd_i(f_pop && !f_empty), .err_i(res_err_i),
    .vx_i(f_dout[2*VW-1:VW]), .vy_i(f_dout[VW-1:0]),
    .best_vx_o(best_vx_o), .best_vy_o(best_vy_o), .best_err_o(best_err_o)
  );

  assign iss_ready_o = !f_full;
  assign res_ready_o = !f_empty;
  assign cur_vx_o    = cur_x;
  assign cur_vy_o    = cur_y;
  assign dir_o       = code_q;
  assign done_o      = done_q;

  AST_CUR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(init_i) |-> (cur_xe >= RLO) && (cur_xe <= RHI) && (cur_ye >= RLO) && (cur_ye <= RHI)); // R7
  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !grad_valid_i) |=> ((cur_xe - $past(cur_xe)) <= 1) && ((cur_xe - $past(cur_xe)) >= -1)
                                 && ((cur_ye - $past(cur_ye)) <= 1) && ((cur_ye - $past(cur_ye)) >= -1)); // R7
  AST_GRAD_TAKES_BEST: assert property (@(posedge clk) disable iff (!rst_n)
    (grad_valid_i && !init_i) |=> done_o || ((cur_x == $past(best_vx_o)) && (cur_y == $past(best_vy_o)))); // R4
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(grad_valid_i || step_i) && !$past(init_i)); // R11
  AST_DONE_HOLDS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $stable(cur_x) && $stable(cur_y)); // R5
endmodule

// File: tb/tb_grad_search_vecgen.sv
`timescale 1ns/1ps
module tb_grad_search_vecgen;
  localparam int VW = 6, GW = 12, EW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_i = 0, grad_valid_i = 0, step_i = 0, iss_valid_i = 0, res_valid_i = 0;
  logic [VW-1:0] pred_vx_i = '0, pred_vy_i = '0;
  logic [GW-1:0] grad_x_i = '0, grad_y_i = '0;
  logic [EW-1:0] res_err_i = '0;
  logic iss_ready_o, res_ready_o, done_o;
  logic [VW-1:0] cur_vx_o, cur_vy_o, best_vx_o, best_vy_o;
  logic [2:0] dir_o;
  logic [EW-1:0] best_err_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  grad_search_vecgen dut (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .pred_vx_i(pred_vx_i), .pred_vy_i(pred_vy_i),
    .grad_valid_i(grad_valid_i), .grad_x_i(grad_x_i), .grad_y_i(grad_y_i), .step_i(step_i),
    .iss_valid_i(iss_valid_i), .iss_ready_o(iss_ready_o),
    .res_valid_i(res_valid_i), .res_err_i(res_err_i), .res_ready_o(res_ready_o),
    .cur_vx_o(cur_vx_o), .cur_vy_o(cur_vy_o), .dir_o(dir_o),
    .best_vx_o(best_vx_o), .best_vy_o(best_vy_o), .best_err_o(best_err_o), .done_o(done_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sv(input logic [VW-1:0] v);
    return int'($signed(v));
  endfunction

  // independent model of the eight-way rounding rule
  function automatic int exp_code(input int gx, input int gy);
    int ax = (gx < 0) ? -gx : gx;
    int ay = (gy < 0) ? -gy : gy;
    int mx = 0, my = 0;
    int tx [8] = '{1, 1, 0, -1, -1, -1, 0, 1};
    int ty [8] = '{0, 1, 1, 1, 0, -1, -1, -1};
    if (!(12*ax < 5*ay) && gx != 0) mx = (gx > 0) ? -1 : 1;
    if (!(12*ay < 5*ax) && gy != 0) my = (gy > 0) ? -1 : 1;
    for (int k = 0; k < 8; k++) if (tx[k] == mx && ty[k] == my) return k;
    return -1;
  endfunction

  task automatic check_cur(input string req, input int ex, input int ey);
    check(req, "cur_vx", sv(cur_vx_o), ex);
    check(req, "cur_vy", sv(cur_vy_o), ey);
  endtask

  task automatic do_init(input int vx, input int vy);
    @(negedge clk); init_i = 1; pred_vx_i = VW'(vx); pred_vy_i = VW'(vy);
    @(negedge clk); init_i = 0;
  endtask
  task automatic do_grad(input int gx, input int gy);
    @(negedge clk); grad_valid_i = 1; grad_x_i = GW'(gx); grad_y_i = GW'(gy);
    @(negedge clk); grad_valid_i = 0;
  endtask
  task automatic do_step();
    @(negedge clk); step_i = 1;
    @(negedge clk); step_i = 0;
  endtask
  task automatic do_issue();
    @(negedge clk); iss_valid_i = 1;
    @(negedge clk); iss_valid_i = 0;
  endtask
  task automatic do_result(input int e);
    @(negedge clk); res_valid_i = 1; res_err_i = EW'(e);
    @(negedge clk); res_valid_i = 0;
  endtask

  task automatic t_reset();
    check("R1", "cur_vx", sv(cur_vx_o), 0);
    check("R1", "best_vy", sv(best_vy_o), 0);
    check("R1", "best_err", int'(best_err_o), 65535);
    check("R1", "done", int'(done_o), 0);
    check("R1", "iss_ready", int'(iss_ready_o), 1);
    check("R1", "res_ready", int'(res_ready_o), 0);
  endtask

  task automatic t_init();
    do_init(3, -2);
    check_cur("R2", 3, -2);
    check("R2", "best_vx", sv(best_vx_o), 3);
    check("R2", "best_vy", sv(best_vy_o), -2);
    check("R2", "best_err", int'(best_err_o), 65535);
    do_issue(); do_issue();
    do_init(0, 0);
    check("R2", "queue flushed", int'(res_ready_o), 0);
  endtask

  task automatic t_quant();
    int gxs [8] = '{10, -10, 0, 8, -5, -4, 12, 12};
    int gys [8] = '{0, 0, 7, 8, 12, 12, -5, -4};
    for (int i = 0; i < 8; i++) begin
      do_init(2, 1);
      do_grad(gxs[i], gys[i]);
      check("R3", $sformatf("dir g=(%0d,%0d)", gxs[i], gys[i]), int'(dir_o), exp_code(gxs[i], gys[i]));
      check("R3", "no done", int'(done_o), 0);
      check_cur("R4", 2, 1);
    end
  endtask

  task automatic t_step_lump();
    do_init(0, 0);
    do_step();
    check_cur("R8 step before dir", 0, 0);
    do_grad(-10, 0);
    for (int i = 1; i <= 3; i++) begin
      do_step();
      check_cur("R7", i, 0);
    end
    do_step();
    check_cur("R8 beyond lump", 3, 0);
    check("R8", "no done", int'(done_o), 0);
    do_grad(0, -10);
    check_cur("R4 back to best", 0, 0);
    do_step();
    check_cur("R4 step count cleared", 0, 1);
  endtask

  task automatic t_pairing();
    do_init(0, 0);
    do_grad(-10, 0);
    do_issue(); do_step(); do_issue(); do_step(); do_issue();
    check("R9", "res_ready", int'(res_ready_o), 1);
    do_result(100);
    check("R10", "best_err", int'(best_err_o), 100);
    check("R10", "best_vx", sv(best_vx_o), 0);
    do_result(50);
    check("R10", "best_vx", sv(best_vx_o), 1);
    do_result(50);
    check("R10 tie keeps", "best_vx", sv(best_vx_o), 1);
    check("R10", "res_ready", int'(res_ready_o), 0);
    do_result(1);
    check("R10 no waiting vector", "best_err", int'(best_err_o), 50);
    do_grad(0, -10);
    check_cur("R4", 1, 0);
  endtask

  task automatic t_backpressure();
    do_init(0, 0);
    do_grad(-10, 0);
    do_issue(); do_step(); do_issue(); do_step(); do_issue(); do_step(); do_issue();
    check("R9", "iss_ready full", int'(iss_ready_o), 0);
    do_issue();
    do_result(40); do_result(30); do_result(20); do_result(10);
    check("R9", "res_ready after 4", int'(res_ready_o), 0);
    check("R10", "best_vx", sv(best_vx_o), 3);
    check("R10", "best_err", int'(best_err_o), 10);
  endtask

  task automatic t_repeat();
    do_init(1, 1);
    do_grad(-10, 0);
    do_step();
    do_grad(-20, 3);
    check("R5", "done", int'(done_o), 1);
    check_cur("R5", 2, 1);
    check("R5", "dir", int'(dir_o), 0);
    @(negedge clk);
    check("R11", "done one cycle", int'(done_o), 0);
  endtask

  task automatic t_limits();
    do_init(0, 0);
    do_grad(-10, 0);
    do_grad(0, -10);
    check("R6", "second accepted", int'(dir_o), 2);
    do_grad(10, 0);
    check("R6", "iteration limit done", int'(done_o), 1);
    check("R6", "dir kept", int'(dir_o), 2);
    do_init(0, 0);
    do_grad(0, 0);
    check("R6", "zero gradient done", int'(done_o), 1);
  endtask

  task automatic t_range();
    do_init(15, 0);
    do_grad(-10, 0);
    do_step();
    check_cur("R7", 16, 0);
    do_step();
    check("R7", "done", int'(done_o), 1);
    check_cur("R7 held", 16, 0);
    do_init(-16, -16);
    do_grad(10, 10);
    do_step();
    check("R7", "done neg", int'(done_o), 1);
    check_cur("R7 held neg", -16, -16);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_init();
    t_quant();
    t_step_lump();
    t_pairing();
    t_backpressure();
    t_repeat();
    t_limits();
    t_range();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule